// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host and an asynchronous 128K x 16 static RAM. It accepts one request at a time through a valid/ready handshake. Each request carries a read/write flag, a 17-bit word address, 16 bits of write data and a 2-bit byte mask. The block turns each request into the strobe sequence the memory needs. It drives the address, active-low chip select, output enable, write enable and one active-low strobe per byte lane, and it controls a split 16-bit data bus with a driver-enable output for the pad ring.

A write is the overlap of chip select, write enable and at least one lane strobe. The memory latches the word on whichever of these strobes rises first. For a single write, the block holds output enable high before it lowers write enable. It keeps its data drivers off until the memory has released the bus, and it turns them off on the same clock edge that raises write enable. When burst mode is on and write requests arrive back to back, write enable stays low from one word to the next. Only the lane strobes pulse for each word, and the address moves only while those strobes are high. Reads lower chip select, output enable and the requested lane strobes, wait an access window and then return the enabled lanes on a one-cycle response.

Every timing minimum is a parameter counted in clock cycles, rounded up from the memory's nanosecond limits. At the 100 MHz default clock, each minimum comes out at one cycle, and a read waits two.

Top module: `asram_lane_ctrl`

## Requirements
- R1: In reset and in idle, chip select, output enable, write enable and both lane strobes are high, the data driver enable is low and req_ready is high.
- R2: Every address from 17'h00000 to 17'h1FFFF can be reached. A word written to an address is returned by a later read of that same address.
- R3: Mask bit 1 enables mem_bs_n[1], which covers data bits 15:8. Mask bit 0 enables mem_bs_n[0], which covers bits 7:0. A write leaves any lane it does not enable unchanged in the memory.
- R4: A read with a non-zero mask holds chip select, output enable and the enabled strobes low for P_READ_ACCESS cycles. rsp_valid then pulses for one cycle, P_READ_ACCESS+1 cycles after the accepting edge. rsp_rdata carries the enabled lanes and zero in the other lanes.
- R5: Output enable is high for at least P_OE_SETUP cycles before write enable falls. The data driver stays off for P_RELEASE cycles after write enable falls. It is on for at least P_DATA_SETUP cycles before the edge that ends each write, and it turns off on that edge.
- R6: A request with a zero mask completes without any strobe going low. For a write it is accepted in one cycle. For a read, rsp_valid follows on the next cycle with all-zero data.
- R7: While burst_en is high and a non-zero-mask write is waiting when a word ends, write enable stays low. That word ends on its lane strobes rising, and the strobes stay high for at least P_BYTE_GAP cycles before the next word.
- R8: Write enable stays low for at least P_WE_PULSE cycles. A burst word's lane strobe pulse lasts at least P_BYTE_PULSE cycles.
- R9: The data driver is enabled only while chip select and write enable are low and output enable is high.
- R10: The address does not change while a write is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_en | input | 1 | Allow write enable to stay low across back-to-back writes |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller accepts the request on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables: bit 1 upper byte, bit 0 lower byte |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bs_n | output | 2 | Lane strobes, active low: bit 1 upper, bit 0 lower |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Data pad driver enable |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
A sequencer that leaves its strobe state too early shows up within the same write. Either the memory model sees the write end without driven data, or the driver enable overlaps a low output enable. A wrong lane decode or a lost mask shows up at the next read of that word, as a mismatched byte in the scoreboard. A burst that drops out of its hold state shows up at once as an extra write-enable falling edge, and a latency counter that is off by one shows up as a response arriving in the wrong cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WREL,
      ST_WDRV,
      ST_BGAP,
      ST_WRAP,
      ST_RD,
      ST_RDONE
   } asram_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_lane_strobe.sv
module asram_lane_strobe #(
   parameter int LANES = 2
) (
   input  logic [LANES-1:0] mask,
   input  logic             active,
   output logic [LANES-1:0] bs_n
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign bs_n[g] = ~(active & mask[g]);
   end
endmodule

// File: rtl/asram_rd_merge.sv
module asram_rd_merge #(
   parameter int LANES = 2
) (
   input  logic [LANES*8-1:0] din,
   input  logic [LANES-1:0]   mask,
   output logic [LANES*8-1:0] dout
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign dout[g*8 +: 8] = mask[g] ? din[g*8 +: 8] : 8'h00;
   end
endmodule

// File: rtl/asram_lane_ctrl.sv
module asram_lane_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W        = 17,
   parameter int DATA_W        = 16,
   parameter int P_OE_SETUP    = 1,
   parameter int P_RELEASE     = 1,
   parameter int P_WE_PULSE    = 1,
   parameter int P_DATA_SETUP  = 1,
   parameter int P_ADDR_SETUP  = 1,
   parameter int P_BYTE_PULSE  = 1,
   parameter int P_BYTE_GAP    = 1,
   parameter int P_RECOVER     = 1,
   parameter int P_WRITE_CYCLE = 1,
   parameter int P_READ_ACCESS = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    burst_en,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_write,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [DATA_W-1:0]       req_wdata,
   input  logic [DATA_W/8-1:0]     req_mask,
   output logic                    rsp_valid,
   output logic [DATA_W-1:0]       rsp_rdata,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic                    mem_ce_n,
   output logic                    mem_oe_n,
   output logic                    mem_we_n,
   output logic [DATA_W/8-1:0]     mem_bs_n,
   output logic [DATA_W-1:0]       mem_dq_out,
   output logic                    mem_dq_oe,
   input  logic [DATA_W-1:0]       mem_dq_in
);
   localparam int LANES      = DATA_W / 8;
   localparam int L_DRV_ONE  = imax(imax(P_DATA_SETUP, P_WE_PULSE - P_RELEASE),
                                    imax(P_ADDR_SETUP - P_OE_SETUP - P_RELEASE, 1));
   localparam int L_DRV_BST  = imax(imax(P_DATA_SETUP, P_BYTE_PULSE), P_ADDR_SETUP);
   localparam int L_BUSY     = P_OE_SETUP + P_RELEASE + L_DRV_ONE;
   localparam int L_RECOVER  = imax(P_RECOVER, P_WRITE_CYCLE - L_BUSY);
   localparam int L_MAX      = imax(imax(imax(P_OE_SETUP, P_RELEASE), imax(L_DRV_ONE, L_DRV_BST)),
                                    imax(imax(P_BYTE_GAP, L_RECOVER), P_READ_ACCESS));
   localparam int CNT_W      = $clog2(L_MAX + 1);

   localparam logic [CNT_W-1:0] K_OE   = CNT_W'(P_OE_SETUP - 1);
   localparam logic [CNT_W-1:0] K_REL  = CNT_W'(P_RELEASE - 1);
   localparam logic [CNT_W-1:0] K_DRV1 = CNT_W'(L_DRV_ONE - 1);
   localparam logic [CNT_W-1:0] K_DRVB = CNT_W'(L_DRV_BST - 1);
   localparam logic [CNT_W-1:0] K_GAP  = CNT_W'(P_BYTE_GAP - 1);
   localparam logic [CNT_W-1:0] K_REC  = CNT_W'(L_RECOVER - 1);
   localparam logic [CNT_W-1:0] K_RD   = CNT_W'(P_READ_ACCESS - 1);

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be a non-zero multiple of 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (P_OE_SETUP < 1 || P_RELEASE < 1 || P_WE_PULSE < 1 || P_DATA_SETUP < 1 ||
       P_ADDR_SETUP < 1 || P_BYTE_PULSE < 1 || P_BYTE_GAP < 1 || P_RECOVER < 1 ||
       P_WRITE_CYCLE < 1 || P_READ_ACCESS < 1) begin : g_bad_timing
      $error("every timing parameter must be at least one cycle");
   end

   asram_state_e          st_q, st_d;
   logic [ADDR_W-1:0]     addr_q;
   logic [DATA_W-1:0]     data_q;
   logic [LANES-1:0]      mask_q;
   logic [DATA_W-1:0]     rdata_q;
   logic [DATA_W-1:0]     merged;
   logic                  t_load;
   logic [CNT_W-1:0]      t_val;
   logic                  t_done;
   logic                  accept;
   logic                  burst_go;
   logic                  cap_rd;
   logic                  zero_rd;
   logic                  lanes_on;

   asram_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .done     (t_done)
   );

   assign burst_go = burst_en && req_valid && req_write && (|req_mask);
   assign accept   = req_valid && req_ready;

   always_comb begin
      st_d      = st_q;
      t_load    = 1'b0;
      t_val     = '0;
      req_ready = 1'b0;
      cap_rd    = 1'b0;
      zero_rd   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            req_ready = 1'b1;
            if (req_valid) begin
               if (req_mask == '0) begin
                  if (!req_write) begin
                     st_d    = ST_RDONE;
                     zero_rd = 1'b1;
                  end
               end else if (req_write) begin
                  st_d   = ST_SETUP;
                  t_load = 1'b1;
                  t_val  = K_OE;
               end else begin
                  st_d   = ST_RD;
                  t_load = 1'b1;
                  t_val  = K_RD;
               end
            end
         end
         ST_SETUP: if (t_done) begin
            st_d   = ST_WREL;
            t_load = 1'b1;
            t_val  = K_REL;
         end
         ST_WREL: if (t_done) begin
            st_d   = ST_WDRV;
            t_load = 1'b1;
            t_val  = K_DRV1;
         end
         ST_WDRV: if (t_done) begin
            t_load = 1'b1;
            if (burst_go) begin
               req_ready = 1'b1;
               st_d      = ST_BGAP;
               t_val     = K_GAP;
            end else begin
               st_d  = ST_WRAP;
               t_val = K_REC;
            end
         end
         ST_BGAP: if (t_done) begin
            st_d   = ST_WDRV;
            t_load = 1'b1;
            t_val  = K_DRVB;
         end
         ST_WRAP: if (t_done) begin
            st_d = ST_IDLE;
         end
         ST_RD: if (t_done) begin
            st_d   = ST_RDONE;
            cap_rd = 1'b1;
         end
         ST_RDONE: st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   asram_rd_merge #(.LANES(LANES)) u_merge (
      .din  (mem_dq_in),
      .mask (mask_q),
      .dout (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
         mask_q  <= '0;
         rdata_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            addr_q <= req_addr;
            data_q <= req_wdata;
            mask_q <= req_mask;
         end
         if (cap_rd) begin
            rdata_q <= merged;
         end else if (zero_rd) begin
            rdata_q <= '0;
         end
      end
   end

   assign lanes_on = (st_q == ST_WREL) || (st_q == ST_WDRV) || (st_q == ST_RD);

   asram_lane_strobe #(.LANES(LANES)) u_strobe (
      .mask   (mask_q),
      .active (lanes_on),
      .bs_n   (mem_bs_n)
   );

   assign mem_addr   = addr_q;
   assign mem_dq_out = data_q;
   assign mem_ce_n   = (st_q == ST_IDLE) || (st_q == ST_RDONE);
   assign mem_oe_n   = (st_q != ST_RD);
   assign mem_we_n   = !((st_q == ST_WREL) || (st_q == ST_WDRV) || (st_q == ST_BGAP));
   assign mem_dq_oe  = (st_q == ST_WDRV);
   assign rsp_valid  = (st_q == ST_RDONE);
   assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/asram_lane_ctrl_chk.sv
module asram_lane_ctrl_chk #(
   parameter int ADDR_W       = 17,
   parameter int LANES        = 2,
   parameter int P_OE_SETUP   = 1,
   parameter int P_WE_PULSE   = 1,
   parameter int P_BYTE_PULSE = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic [LANES-1:0]  req_mask,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [LANES-1:0]  mem_bs_n,
   input logic              mem_dq_oe
);
   logic [7:0] oe_hi_cnt, we_lo_cnt, bs_lo_cnt;
   logic       wr_active, bs_any;

   assign bs_any    = (mem_bs_n != {LANES{1'b1}});
   assign wr_active = !mem_ce_n && !mem_we_n && bs_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_hi_cnt <= '0;
         we_lo_cnt <= '0;
         bs_lo_cnt <= '0;
      end else begin
         oe_hi_cnt <= !mem_oe_n ? 8'd0 : ((oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1);
         we_lo_cnt <= mem_we_n ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
         bs_lo_cnt <= !bs_any ? 8'd0 : ((bs_lo_cnt == 8'hFF) ? bs_lo_cnt : bs_lo_cnt + 8'd1);
      end
   end

   assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

   assert_oe_before_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> (oe_hi_cnt >= 8'(P_OE_SETUP) && !mem_dq_oe));

   assert_drv_off_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_dq_oe && $past(mem_dq_oe)));

   assert_zero_mask_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write && req_mask == '0) |=> (mem_ce_n && mem_bs_n == {LANES{1'b1}}));

   assert_burst_lane_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n) && !bs_any && $past(bs_any)) |-> (!mem_dq_oe && bs_lo_cnt >= 8'(P_BYTE_PULSE)));

   assert_we_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_lo_cnt >= 8'(P_WE_PULSE)));

   assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (mem_oe_n && !mem_we_n && !mem_ce_n));

   assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_active && $past(wr_active)) |-> $stable(mem_addr));
endmodule

bind asram_lane_ctrl asram_lane_ctrl_chk #(
   .ADDR_W       (ADDR_W),
   .LANES        (DATA_W/8),
   .P_OE_SETUP   (P_OE_SETUP),
   .P_WE_PULSE   (P_WE_PULSE),
   .P_BYTE_PULSE (P_BYTE_PULSE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_write (req_write),
   .req_mask  (req_mask),
   .mem_addr  (mem_addr),
   .mem_ce_n  (mem_ce_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_bs_n  (mem_bs_n),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_lane_ctrl_tb.sv
module asram_lane_ctrl_tb;
   localparam int AW = 17;
   localparam int DW = 16;
   localparam int RD_LAT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          burst_en = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_mask = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [1:0]    mem_bs_n;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int we_falls = 0;
   int ce_falls = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   asram_lane_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .burst_en(burst_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // ---------------- behavioural memory model ----------------
   logic [DW-1:0] model_mem [int];
   logic [DW-1:0] shadow    [int];
   int            model_upd = 0;

   function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
      return model_mem.exists(int'(a)) ? model_mem[int'(a)] : 16'h0000;
   endfunction

   always @(mem_addr or mem_ce_n or mem_oe_n or mem_we_n or model_upd) begin
      mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? model_rd(mem_addr) : 16'h0000;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   bit            p_act = 1'b0;
   logic [AW-1:0] p_addr;
   logic [1:0]    p_bs;
   logic [DW-1:0] p_data;
   bit            p_oe;
   bit            p_we_n = 1'b1;
   bit            p_ce_n = 1'b1;

   always @(negedge clk) begin
      automatic bit c_act = rst_n && !mem_ce_n && !mem_we_n && (mem_bs_n != 2'b11);
      if (rst_n && mem_dq_oe && !mem_oe_n) check("R9 contention", 32'd1, 32'd0);
      if (p_act && !(c_act && mem_addr == p_addr && mem_bs_n == p_bs)) begin
         automatic logic [DW-1:0] w = model_rd(p_addr);
         check("R5 data driven at write end", {31'd0, p_oe}, 32'd1);
         if (!p_bs[1]) w[15:8] = p_data[15:8];
         if (!p_bs[0]) w[7:0]  = p_data[7:0];
         model_mem[int'(p_addr)] = w;
         model_upd++;
      end
      if (rst_n && p_we_n && !mem_we_n) we_falls++;
      if (rst_n && p_ce_n && !mem_ce_n) ce_falls++;
      p_act  = c_act;
      p_addr = mem_addr;
      p_bs   = mem_bs_n;
      p_data = mem_dq_out;
      p_oe   = mem_dq_oe;
      p_we_n = mem_we_n;
      p_ce_n = mem_ce_n;
   end

   // ---------------- scoreboard ----------------
   logic [DW-1:0] exp_q [$];
   int            lat_q [$];

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check("R4 unexpected response", 32'd1, 32'd0);
         end else begin
            automatic logic [DW-1:0] e = exp_q.pop_front();
            automatic int t = lat_q.pop_front();
            check("R2/R3/R4 read data", {16'd0, rsp_rdata}, {16'd0, e});
            check("R4 response cycle", cyc, t);
         end
      end
   end

   task automatic send(input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [1:0] m);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
      while (!req_ready) @(negedge clk);
      if (wr) begin
         automatic logic [DW-1:0] s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
         if (m[1]) s[15:8] = d[15:8];
         if (m[0]) s[7:0]  = d[7:0];
         shadow[int'(a)] = s;
      end else begin
         automatic logic [DW-1:0] s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
         exp_q.push_back({m[1] ? s[15:8] : 8'h00, m[0] ? s[7:0] : 8'h00});
         lat_q.push_back((m == 2'b00) ? cyc + 1 : cyc + RD_LAT + 1);
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      int ce_before;
      int we_before;
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 strobes in reset", {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n}, 32'h1F);
      check("R1 driver off in reset", {31'd0, mem_dq_oe}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready in idle", {31'd0, req_ready}, 32'd1);

      // R2: full words at both ends of the address range
      send(1, 17'h00000, 16'hA5C3, 2'b11);
      send(1, 17'h1FFFF, 16'h3C5A, 2'b11);
      send(1, 17'h0ABCD, 16'h1234, 2'b11);
      send(0, 17'h00000, 16'h0, 2'b11);
      send(0, 17'h1FFFF, 16'h0, 2'b11);
      idle(6);

      // R3: byte lane writes
      send(1, 17'h0ABCD, 16'hEE00, 2'b10);
      send(1, 17'h00010, 16'hFFFF, 2'b11);
      send(1, 17'h00010, 16'h0077, 2'b01);
      send(0, 17'h0ABCD, 16'h0, 2'b11);
      send(0, 17'h00010, 16'h0, 2'b11);
      idle(6);

      // R4: partial read lanes
      send(0, 17'h0ABCD, 16'h0, 2'b01);
      send(0, 17'h0ABCD, 16'h0, 2'b10);
      idle(6);

      // R6: zero-mask requests
      ce_before = ce_falls;
      send(1, 17'h0ABCD, 16'h9999, 2'b00);
      send(0, 17'h0ABCD, 16'h0, 2'b00);
      idle(4);
      check("R6 no chip select for zero mask", ce_falls, ce_before);
      send(0, 17'h0ABCD, 16'h0, 2'b11);
      idle(6);

      // R7: burst of three words under one write-enable pulse
      burst_en = 1'b1;
      we_before = we_falls;
      send(1, 17'h00100, 16'h1111, 2'b11);
      send(1, 17'h00101, 16'h2222, 2'b01);
      send(1, 17'h00102, 16'h3333, 2'b10);
      idle(6);
      check("R7 single write-enable fall in burst", we_falls - we_before, 1);
      burst_en = 1'b0;
      send(0, 17'h00100, 16'h0, 2'b11);
      send(0, 17'h00101, 16'h0, 2'b11);
      send(0, 17'h00102, 16'h0, 2'b11);
      idle(6);

      // burst_en low: each write gets its own write-enable pulse
      we_before = we_falls;
      send(1, 17'h00200, 16'h4444, 2'b11);
      send(1, 17'h00201, 16'h5555, 2'b11);
      idle(6);
      check("R7 separate pulses without burst", we_falls - we_before, 2);
      send(0, 17'h00201, 16'h0, 2'b11);
      idle(6);

      check("R4 scoreboard drained", exp_q.size(), 0);
      check("R1 idle strobes at end", {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n}, 32'h1F);
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end
endmodule